// File: doc/BRIEF.md
# Interrupt Pending and Active State Tracker

This block holds a two-bit state for each of a set of peripheral interrupt request lines: a pending bit and an active bit. The four combinations are inactive, pending, active, and active with a new request pending. Hardware requests arrive as raw, asynchronous level lines. Software can set pending bits through a bit mask, clear them through a second mask, or set one line by writing its binary interrupt number to a trigger strobe. A service controller reports that it has entered or left the handler of an interrupt number. The pending and active vectors are registered outputs, and line k always sits at bit k.

A request line that is still high when its handler returns is sampled again at that moment and becomes pending once more. A pulse that arrives while the handler runs is also caught. No line can lose a request while it is in service, and a peripheral can keep its line high until it has no more work. Arbitration, enable masking and vector fetch are handled by other logic that reads the two vectors.

Top module: `irq_state_tracker`

## Requirements
- R1: When a synchronized request line is high and its active bit is 0, its pending bit becomes 1. A change on `irq_in` reaches the pending bit three clock edges later (two synchronizer flops, then the state register).
- R2: A rising edge on a synchronized request line sets its pending bit, even while its active bit is 1.
- R3: A strobe on `sw_set_we` sets the pending bit of every line whose `sw_set_mask` bit is 1. A strobe on `sw_trig_we` with binary number k below N_LINES sets pending bit k. Both take effect on the next clock edge.
- R4: A strobe on `sw_clr_we` clears the pending bit of every line whose `sw_clr_mask` bit is 1, on the next clock edge, provided no set source hits that line.
- R5: An `entry_valid` strobe for a line that is pending sets its active bit. Its pending bit is cleared unless the synchronized line is still high, in which case pending stays 1.
- R6: A `return_valid` strobe for line k clears active bit k. Pending bit k is then 1 if the synchronized line is high and 0 otherwise, unless another set source hits line k or pending was already 1.
- R7: If a line pulses while its active bit is 1, its pending bit is 1 after the return.
- R8: When a set source and a clear source hit the same line in the same cycle, the set wins and the pending bit is 1.
- R9: Entry, return and trigger numbers of N_LINES or above change no state and raise no error.
- R10: An entry strobe for an in-range line whose pending bit is 0 leaves that line's state unchanged. It drives `entry_err_o` high for exactly the one cycle after the strobe.
- R11: Synchronous reset clears all pending bits, all active bits and `entry_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Raw asynchronous request lines, bit k is line k |
| sw_set_we | input | 1 | Software set-pending strobe |
| sw_set_mask | input | N_LINES | Lines to make pending |
| sw_clr_we | input | 1 | Software clear-pending strobe |
| sw_clr_mask | input | N_LINES | Lines to clear |
| sw_trig_we | input | 1 | Software trigger strobe |
| sw_trig_num | input | NUM_W | Binary number of the line to trigger |
| entry_valid | input | 1 | Handler entry strobe |
| entry_num | input | NUM_W | Number of the entered interrupt |
| return_valid | input | 1 | Handler return strobe |
| return_num | input | NUM_W | Number of the returning interrupt |
| pending_o | output | N_LINES | Pending bits |
| active_o | output | N_LINES | Active bits |
| entry_err_o | output | 1 | One-cycle flag for an entry on a non-pending line |

## Verification
The bench builds the block with N_LINES=4 and NUM_W=3. This makes numbers 4 to 7 out of range. Every line, and every out-of-range number for entry, return and trigger, can then be swept in a few thousand cycles. For each line the bench steps through the full lifecycle: level request, entry with the line held, a pulse during service, return with the line high and with it low, and set and clear in the same cycle. Because the lines are exercised one at a time, any crosstalk between neighbouring bits shows up at the ports.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  typedef struct packed {
    logic pend;
    logic act;
  } line_st_t;
endpackage

// File: rtl/irqt_sync.sv
module irqt_sync #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] rise_o
);
  logic [N_LINES-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/irqt_decode.sv
module irqt_decode #(
  parameter int N_LINES = 8,
  parameter int NUM_W   = 4
) (
  input  logic               valid_i,
  input  logic [NUM_W-1:0]   num_i,
  output logic [N_LINES-1:0] hit_o
);
  always_comb begin
    hit_o = '0;
    for (int k = 0; k < N_LINES; k++) begin
      if (valid_i && (int'(num_i) == k)) hit_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/irqt_cell.sv
module irqt_cell
  import irqt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ent_i,
  input  logic ret_i,
  output logic pend_o,
  output logic act_o
);
  line_st_t st_q, st_n;
  logic go, hw_set, base;

  always_comb begin
    go      = ent_i & st_q.pend;
    hw_set  = rise_i | (lvl_i & (~st_q.act | ret_i | go));
    base    = go ? 1'b0 : st_q.pend;
    st_n.pend = hw_set | set_i | (base & ~clr_i);
    if (go)         st_n.act = 1'b1;
    else if (ret_i) st_n.act = 1'b0;
    else            st_n.act = st_q.act;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_n;
  end

  assign pend_o = st_q.pend;
  assign act_o  = st_q.act;
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int N_LINES = 8,
  parameter int NUM_W   = $clog2(N_LINES) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               sw_set_we,
  input  logic [N_LINES-1:0] sw_set_mask,
  input  logic               sw_clr_we,
  input  logic [N_LINES-1:0] sw_clr_mask,
  input  logic               sw_trig_we,
  input  logic [NUM_W-1:0]   sw_trig_num,
  input  logic               entry_valid,
  input  logic [NUM_W-1:0]   entry_num,
  input  logic               return_valid,
  input  logic [NUM_W-1:0]   return_num,
  output logic [N_LINES-1:0] pending_o,
  output logic [N_LINES-1:0] active_o,
  output logic               entry_err_o
);
  logic [N_LINES-1:0] lvl, rise, trig_hit, ent_hit, ret_hit, set_v, clr_v;
  logic               err_q;

  irqt_sync #(.N_LINES(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(irq_in), .lvl_o(lvl), .rise_o(rise)
  );

  irqt_decode #(.N_LINES(N_LINES), .NUM_W(NUM_W)) u_dec_trig (
    .valid_i(sw_trig_we), .num_i(sw_trig_num), .hit_o(trig_hit)
  );
  irqt_decode #(.N_LINES(N_LINES), .NUM_W(NUM_W)) u_dec_ent (
    .valid_i(entry_valid), .num_i(entry_num), .hit_o(ent_hit)
  );
  irqt_decode #(.N_LINES(N_LINES), .NUM_W(NUM_W)) u_dec_ret (
    .valid_i(return_valid), .num_i(return_num), .hit_o(ret_hit)
  );

  assign set_v = trig_hit | (sw_set_we ? sw_set_mask : '0);
  assign clr_v = sw_clr_we ? sw_clr_mask : '0;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    irqt_cell u_cell (
      .clk(clk), .rst(rst),
      .lvl_i(lvl[g]), .rise_i(rise[g]),
      .set_i(set_v[g]), .clr_i(clr_v[g]),
      .ent_i(ent_hit[g]), .ret_i(ret_hit[g]),
      .pend_o(pending_o[g]), .act_o(active_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= |(ent_hit & ~pending_o);
  end

  assign entry_err_o = err_q;
endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
  parameter int N_LINES = 8,
  parameter int NUM_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               sw_set_we,
  input logic [N_LINES-1:0] sw_set_mask,
  input logic               entry_valid,
  input logic [NUM_W-1:0]   entry_num,
  input logic               return_valid,
  input logic [NUM_W-1:0]   return_num,
  input logic [N_LINES-1:0] pending_o,
  input logic [N_LINES-1:0] active_o,
  input logic               entry_err_o
);
  p_err_after_entry_r10: assert property (@(posedge clk) disable iff (rst)
    entry_err_o |-> $past(entry_valid));

  p_range_no_err_r9: assert property (@(posedge clk) disable iff (rst)
    (entry_valid && int'(entry_num) >= N_LINES) |=> !entry_err_o);

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    p_entry_sets_active_r5: assert property (@(posedge clk) disable iff (rst)
      (entry_valid && int'(entry_num) == g && pending_o[g]) |=> active_o[g]);

    p_active_only_by_entry_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(active_o[g]) |-> ($past(entry_valid) && int'($past(entry_num)) == g));

    p_return_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (return_valid && int'(return_num) == g && !(entry_valid && int'(entry_num) == g))
      |=> !active_o[g]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (sw_set_we && sw_set_mask[g]) |=> pending_o[g]);
  end
endmodule

bind irq_state_tracker irq_state_tracker_chk #(.N_LINES(N_LINES), .NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst(rst), .sw_set_we(sw_set_we), .sw_set_mask(sw_set_mask),
  .entry_valid(entry_valid), .entry_num(entry_num),
  .return_valid(return_valid), .return_num(return_num),
  .pending_o(pending_o), .active_o(active_o), .entry_err_o(entry_err_o)
);

// File: tb/sim_irq_state_tracker.sv
module sim_irq_state_tracker;
  localparam int N = 4;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] irq_in, set_mask, clr_mask;
  logic         set_we, clr_we, trig_we, ent_v, ret_v;
  logic [W-1:0] trig_num, ent_num, ret_num;
  logic [N-1:0] pend, act;
  logic         err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_state_tracker #(.N_LINES(N), .NUM_W(W)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .sw_set_we(set_we), .sw_set_mask(set_mask),
    .sw_clr_we(clr_we), .sw_clr_mask(clr_mask),
    .sw_trig_we(trig_we), .sw_trig_num(trig_num),
    .entry_valid(ent_v), .entry_num(ent_num),
    .return_valid(ret_v), .return_num(ret_num),
    .pending_o(pend), .active_o(act), .entry_err_o(err)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_clear();
    set_we = 0; clr_we = 0; trig_we = 0; ent_v = 0; ret_v = 0;
  endtask

  task automatic do_entry(input int k);
    ent_v = 1; ent_num = W'(k); @(negedge clk); strobe_clear();
  endtask

  task automatic do_return(input int k);
    ret_v = 1; ret_num = W'(k); @(negedge clk); strobe_clear();
  endtask

  task automatic do_clear(input logic [N-1:0] m);
    clr_we = 1; clr_mask = m; @(negedge clk); strobe_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; irq_in = '0; set_mask = '0; clr_mask = '0;
    trig_num = '0; ent_num = '0; ret_num = '0;
    strobe_clear();
    idle(3);
    check("R11 pending", 8'(pend), 0);
    check("R11 active", 8'(act), 0);
    check("R11 err", 8'(err), 0);
    rst = 0;
    idle(2);

    for (int i = 0; i < N; i++) begin
      logic [N-1:0] b;
      b = N'(1) << i;
      // R1: level request, three edges of latency
      irq_in = b; idle(2);
      check("R1 latency", 8'(pend), 0);
      idle(1);
      check("R1 level", 8'(pend), 8'(b));
      // R9: out-of-range entry ignored
      for (int n = N; n < (1 << W); n++) begin
        do_entry(n);
        check("R9 entry range act", 8'(act), 0);
        check("R9 entry range err", 8'(err), 0);
      end
      // R5: entry with line held keeps pending
      do_entry(i);
      check("R5 active", 8'(act), 8'(b));
      check("R5 pend held", 8'(pend), 8'(b));
      // R4: clear while active, no edge
      do_clear(b);
      check("R4 clear", 8'(pend), 0);
      // R9: out-of-range return ignored
      do_return(N + i % N);
      check("R9 return range", 8'(act), 8'(b));
      // R2: pulse while active
      irq_in = '0; idle(3);
      check("R2 before", 8'(pend), 0);
      irq_in = b; idle(3);
      check("R2 edge active", 8'(pend), 8'(b));
      irq_in = '0; idle(3);
      // R7: pending after return
      do_return(i);
      check("R7 act", 8'(act), 0);
      check("R7 pend", 8'(pend), 8'(b));
      // R5: entry with line low clears pending
      do_entry(i);
      check("R5 entry low pend", 8'(pend), 0);
      check("R5 entry low act", 8'(act), 8'(b));
      // R6: return with line low -> inactive
      do_return(i);
      check("R6 inactive pend", 8'(pend), 0);
      check("R6 inactive act", 8'(act), 0);
      // R6: return with line high -> pending
      irq_in = b; idle(3);
      do_entry(i);
      do_clear(b);
      check("R6 setup", 8'(pend), 0);
      do_return(i);
      check("R6 relevel pend", 8'(pend), 8'(b));
      check("R6 relevel act", 8'(act), 0);
      irq_in = '0; idle(3);
      do_clear(b);
      check("R4 idle clear", 8'(pend), 0);
      // R3: mask set and trigger
      set_we = 1; set_mask = b; @(negedge clk); strobe_clear();
      check("R3 mask", 8'(pend), 8'(b));
      do_clear(b);
      trig_we = 1; trig_num = W'(i); @(negedge clk); strobe_clear();
      check("R3 trig", 8'(pend), 8'(b));
      do_clear(b);
      // R9: out-of-range trigger
      trig_we = 1; trig_num = W'(N + i); @(negedge clk); strobe_clear();
      check("R9 trig range", 8'(pend), 0);
      // R8: set and clear together
      set_we = 1; set_mask = b; clr_we = 1; clr_mask = b;
      @(negedge clk); strobe_clear();
      check("R8 set wins", 8'(pend), 8'(b));
      do_clear(b);
      // R10: entry on non-pending line
      do_entry(i);
      check("R10 err", 8'(err), 1);
      check("R10 act", 8'(act), 0);
      idle(1);
      check("R10 err one cycle", 8'(err), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule